// File: doc/BRIEF.md
# SPI Configuration Loader Sequencer

This block is an SPI master that loads a configuration bitstream into a target device through the target's slave configuration port. A single start pulse runs a fixed sequence with no further help from the host. The block first reads and checks the 32-bit device identifier, then reads status once. It sends three preparation commands (refresh, write enable, clear) and polls status until the target reports that its configuration memory is cleared. It then streams the whole bitstream behind a write-increment header inside one chip-select frame. Finally it disables writes and reads status again to confirm that configuration finished.

Bitstream bytes arrive on a valid/ready byte stream, and the byte count is sampled on the start pulse. The host only watches `busy` and reads the outcome on `success` and `err_code`. All SPI traffic uses mode 0 (clock idles low, data sampled on the rising edge), most significant bit first. The SCLK half-period is set by a divider parameter, and the poll interval by a tick-count parameter. TICK_CYCLES must be at least 2*CLK_DIV.

Top module: `cfgl_loader`

## Requirements
- R1: A start pulse with a byte count of zero sets err_code to 1 (length error) and leaves success low and busy low, and the block sends no SPI traffic (CS_n stays high).
- R2: The identifier read is one 8-byte frame: opcode 0x07, then seven 0x00 bytes. The identifier is the 32-bit word formed by received bytes 4..7, with the first of those bytes as the most significant.
- R3: Only identifiers 0xC2088080 and 0xC2048080 are accepted. Any other identifier ends the run after the identifier frame with err_code 2.
- R4: After identification the frames come in this order: status read (opcode 0x09, 8 bytes, word from received bytes 4..7), refresh 0x71, write enable 0x4A, clear 0x70. The last three are 4-byte frames, and every byte after the opcode in all of these frames is 0x00.
- R5: After clear, status reads repeat until a status word equals exactly 0x00010000. Consecutive poll frames start at least TICK_CYCLES clock cycles apart.
- R6: If MAX_POLLS polls in a row do not return 0x00010000, the run ends with err_code 3 and no programming frame is sent.
- R7: The programming frame is one continuous CS_n assertion of N+8 bytes: 0x41, three 0xFF bytes, the N bitstream bytes in arrival order, then four 0x00 bytes.
- R8: While the bitstream source holds valid low during the programming frame, CS_n stays low and SCLK holds its level.
- R9: After the programming frame the block sends write disable (0x4F, 4 bytes) and then a status read. If bit 14 (mask 0x00004000) is set, success goes high with err_code 0. Otherwise err_code is 4.
- R10: SPI is mode 0, MSB first. MOSI does not change while SCLK is high, SCLK is low whenever CS_n is high, and CS_n stays high for at least 2*CLK_DIV clock cycles between frames.
- R11: After reset all outputs are low except CS_n, which is high. busy is high from an accepted start until the result is posted. success and err_code keep their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; ignored while busy |
| bs_len | input | LEN_W | Bitstream byte count, sampled on start |
| bs_data | input | 8 | Bitstream byte |
| bs_valid | input | 1 | bs_data holds a byte |
| bs_ready | output | 1 | Block takes bs_data this cycle if bs_valid is high |
| spi_miso | input | 1 | Serial data from target |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to target |
| spi_cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Sequence in progress |
| success | output | 1 | Last run configured the target |
| err_code | output | 3 | 0 none, 1 zero length, 2 unknown identifier, 3 clear timeout, 4 done flag not set |

## Verification
The bench builds the block with CLK_DIV=2, TICK_CYCLES=300, MAX_POLLS=4 and LEN_W=16. The short poll interval and the poll limit of four make the clear timeout reachable within a few thousand cycles, along with the exact spacing between polls. The fast divider keeps full runs, including a programming frame stalled by its source, short enough to repeat with both accepted identifiers and with every error outcome.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [3:0] {
    F_ID, F_ST0, F_REF, F_WEN, F_CLR, F_POLL, F_PROG, F_WDIS, F_STF
  } frame_e;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP, S_WAIT} seq_e;

  localparam logic [7:0] OP_ID      = 8'h07;
  localparam logic [7:0] OP_STAT    = 8'h09;
  localparam logic [7:0] OP_REFRESH = 8'h71;
  localparam logic [7:0] OP_WREN    = 8'h4A;
  localparam logic [7:0] OP_CLEAR   = 8'h70;
  localparam logic [7:0] OP_PROG    = 8'h41;
  localparam logic [7:0] OP_WRDIS   = 8'h4F;

  localparam logic [31:0] DEV_ID_A     = 32'hC208_8080;
  localparam logic [31:0] DEV_ID_B     = 32'hC204_8080;
  localparam logic [31:0] ST_CLEARED   = 32'h0001_0000;
  localparam logic [31:0] ST_DONE_MASK = 32'h0000_4000;

  localparam logic [2:0] ERR_NONE = 3'd0;
  localparam logic [2:0] ERR_LEN  = 3'd1;
  localparam logic [2:0] ERR_ID   = 3'd2;
  localparam logic [2:0] ERR_TMO  = 3'd3;
  localparam logic [2:0] ERR_DONE = 3'd4;

endpackage

// File: rtl/cfgl_spi_byte.sv
module cfgl_spi_byte #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       done
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);

  logic             active;
  logic             sclk_q;
  logic [7:0]       shreg;
  logic [7:0]       rxreg;
  logic [2:0]       bitn;
  logic [DIV_W-1:0] div_cnt;
  logic             done_q;
  logic             half_end;

  assign half_end = active && (div_cnt == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk_q  <= 1'b0;
      shreg   <= '0;
      rxreg   <= '0;
      bitn    <= '0;
      div_cnt <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          shreg   <= tx_byte;
          bitn    <= '0;
          div_cnt <= '0;
          sclk_q  <= 1'b0;
        end
      end else if (half_end) begin
        div_cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rxreg  <= {rxreg[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bitn  <= bitn + 3'd1;
            shreg <= {shreg[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = shreg[7];
  assign rx_byte = rxreg;
  assign done    = done_q;

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi)); // R10

  AST_ONE_BYTE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active); // R10

endmodule

// File: rtl/cfgl_tick.sv
module cfgl_tick #(
  parameter int TICK_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int TW = $clog2(TICK_CYCLES + 1);

  logic          running;
  logic [TW-1:0] cnt;
  logic          expire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cnt      <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (running) begin
        if (cnt == TW'(TICK_CYCLES - 1)) begin
          running  <= 1'b0;
          expire_q <= 1'b1;
        end else begin
          cnt <= cnt + TW'(1);
        end
      end
    end
  end

  assign expire = expire_q;

  AST_TICK_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> !running); // R5

endmodule

// File: rtl/cfgl_loader.sv
module cfgl_loader
  import cfgl_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int TICK_CYCLES = 500000,
  parameter int MAX_POLLS   = 500,
  parameter int LEN_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] bs_len,
  input  logic [7:0]       bs_data,
  input  logic             bs_valid,
  output logic             bs_ready,
  input  logic             spi_miso,
  output logic             spi_sclk,
  output logic             spi_mosi,
  output logic             spi_cs_n,
  output logic             busy,
  output logic             success,
  output logic [2:0]       err_code
);
  localparam int FLEN_W  = LEN_W + 1;
  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam int PC_W    = $clog2(MAX_POLLS + 1);

  // ---- frame arithmetic ----
  function automatic logic [FLEN_W-1:0] frame_len(frame_e f, logic [LEN_W-1:0] n);
    case (f)
      F_ID, F_ST0, F_POLL, F_STF: return FLEN_W'(8);
      F_PROG:                     return FLEN_W'(n) + FLEN_W'(8);
      default:                    return FLEN_W'(4);
    endcase
  endfunction

  function automatic logic [7:0] opcode_of(frame_e f);
    case (f)
      F_ID:    return OP_ID;
      F_REF:   return OP_REFRESH;
      F_WEN:   return OP_WREN;
      F_CLR:   return OP_CLEAR;
      F_PROG:  return OP_PROG;
      F_WDIS:  return OP_WRDIS;
      default: return OP_STAT;
    endcase
  endfunction

  function automatic logic is_data_byte(frame_e f, logic [FLEN_W-1:0] idx,
                                        logic [LEN_W-1:0] n);
    return (f == F_PROG) && (idx >= FLEN_W'(4)) && (idx < FLEN_W'(n) + FLEN_W'(4));
  endfunction

  function automatic logic [7:0] frame_byte(frame_e f, logic [FLEN_W-1:0] idx,
                                            logic [LEN_W-1:0] n, logic [7:0] d);
    if (idx == '0)                    return opcode_of(f);
    if (f != F_PROG)                  return 8'h00;
    if (idx < FLEN_W'(4))             return 8'hFF;
    if (is_data_byte(f, idx, n))      return d;
    return 8'h00;
  endfunction

  function automatic logic id_ok(logic [31:0] w);
    return (w == DEV_ID_A) || (w == DEV_ID_B);
  endfunction

  function automatic frame_e next_after(frame_e f);
    case (f)
      F_ST0:   return F_REF;
      F_REF:   return F_WEN;
      F_WEN:   return F_CLR;
      F_CLR:   return F_POLL;
      F_PROG:  return F_WDIS;
      F_WDIS:  return F_STF;
      default: return F_ID;
    endcase
  endfunction

  // ---- state ----
  seq_e              st;
  frame_e            fr;
  logic [FLEN_W-1:0] byte_idx;
  logic              inflight;
  logic [31:0]       word;
  logic [PC_W-1:0]   poll_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic [LEN_W-1:0]  len_q;
  logic              busy_q;
  logic              ok_q;
  logic [2:0]        err_q;

  // ---- named internal events ----
  logic        frame_active;
  logic        need_data;
  logic        byte_go;
  logic        byte_done;
  logic        frame_last;
  logic        frame_end;
  logic        prog_stall;
  logic        tick_start;
  logic        tick_expire;
  logic [7:0]  tx_byte;
  logic [7:0]  rx_byte;
  logic [31:0] word_next;

  assign frame_active = (st == S_FRAME);
  assign need_data    = is_data_byte(fr, byte_idx, len_q);
  assign byte_go      = frame_active && !inflight && (!need_data || bs_valid);
  assign prog_stall   = frame_active && !inflight && need_data && !bs_valid;
  assign bs_ready     = frame_active && !inflight && need_data;
  assign tx_byte      = frame_byte(fr, byte_idx, len_q, bs_data);
  assign word_next    = {word[23:0], rx_byte};
  assign frame_last   = (byte_idx == frame_len(fr, len_q) - FLEN_W'(1));
  assign frame_end    = byte_done && frame_last;
  assign tick_start   = frame_end && (fr == F_POLL) && (word_next != ST_CLEARED)
                        && (poll_cnt != PC_W'(MAX_POLLS - 1));

  cfgl_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (byte_go),
    .tx_byte (tx_byte),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .rx_byte (rx_byte),
    .done    (byte_done)
  );

  cfgl_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tick_start),
    .expire (tick_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      fr       <= F_ID;
      byte_idx <= '0;
      inflight <= 1'b0;
      word     <= '0;
      poll_cnt <= '0;
      gap_cnt  <= '0;
      len_q    <= '0;
      busy_q   <= 1'b0;
      ok_q     <= 1'b0;
      err_q    <= ERR_NONE;
    end else begin
      if (byte_go) inflight <= 1'b1;
      if (byte_done) begin
        inflight <= 1'b0;
        word     <= word_next;
        byte_idx <= byte_idx + FLEN_W'(1);
      end
      case (st)
        S_IDLE: begin
          if (start) begin
            ok_q <= 1'b0;
            if (bs_len == '0) begin
              err_q <= ERR_LEN;
            end else begin
              err_q    <= ERR_NONE;
              busy_q   <= 1'b1;
              len_q    <= bs_len;
              fr       <= F_ID;
              byte_idx <= '0;
              st       <= S_FRAME;
            end
          end
        end
        S_FRAME: begin
          if (frame_end) begin
            byte_idx <= '0;
            gap_cnt  <= '0;
            case (fr)
              F_ID: begin
                if (id_ok(word_next)) begin
                  fr <= F_ST0;
                  st <= S_GAP;
                end else begin
                  st     <= S_IDLE;
                  busy_q <= 1'b0;
                  err_q  <= ERR_ID;
                end
              end
              F_POLL: begin
                if (word_next == ST_CLEARED) begin
                  fr <= F_PROG;
                  st <= S_GAP;
                end else if (poll_cnt == PC_W'(MAX_POLLS - 1)) begin
                  st     <= S_IDLE;
                  busy_q <= 1'b0;
                  err_q  <= ERR_TMO;
                end else begin
                  poll_cnt <= poll_cnt + PC_W'(1);
                  st       <= S_WAIT;
                end
              end
              F_STF: begin
                st     <= S_IDLE;
                busy_q <= 1'b0;
                if ((word_next & ST_DONE_MASK) != '0) ok_q <= 1'b1;
                else                                  err_q <= ERR_DONE;
              end
              default: begin
                if (fr == F_CLR) poll_cnt <= '0;
                fr <= next_after(fr);
                st <= S_GAP;
              end
            endcase
          end
        end
        S_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1)) st <= S_FRAME;
          else                                gap_cnt <= gap_cnt + GAP_W'(1);
        end
        S_WAIT: begin
          if (tick_expire) st <= S_FRAME;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign spi_cs_n = !frame_active;
  assign busy     = busy_q;
  assign success  = ok_q;
  assign err_code = err_q;

  AST_NO_TRAFFIC_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bs_len == '0) |=> (spi_cs_n && !busy && err_code == ERR_LEN)); // R1

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R10

  AST_STALL_HOLDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stall |=> ($stable(spi_sclk) && !spi_cs_n)); // R8

  AST_READY_ONLY_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    bs_ready |-> (fr == F_PROG && !spi_cs_n)); // R7

  AST_RESULT_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (success != (err_code != ERR_NONE))); // R11

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(success) && $stable(err_code))); // R11

endmodule

// File: tb/cfgl_loader_tb_top.sv
`timescale 1ns/1ps
module cfgl_loader_tb_top;
  localparam int CLK_DIV = 2;
  localparam int TICK    = 300;
  localparam int MAXP    = 4;
  localparam int LEN_W   = 16;
  localparam real TCK    = 4.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] bs_len = '0;
  logic [7:0] bs_data = '0;
  logic bs_valid = 1'b0;
  logic bs_ready;
  logic spi_miso = 1'b0;
  logic spi_sclk, spi_mosi, spi_cs_n, busy, success;
  logic [2:0] err_code;

  always #2 clk = ~clk;

  cfgl_loader #(.CLK_DIV(CLK_DIV), .TICK_CYCLES(TICK), .MAX_POLLS(MAXP), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bs_len(bs_len), .bs_data(bs_data),
    .bs_valid(bs_valid), .bs_ready(bs_ready), .spi_miso(spi_miso), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .busy(busy), .success(success),
    .err_code(err_code));

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---- target model ----
  logic [31:0] id_val, final_st, cur_st;
  int   poll_ok_at;
  bit   logging = 0, clr_seen, prog_seen, pad_bad;
  int   polls, nfr, bitc, bytec, prog_len;
  logic [7:0] rxs, tx_sh, cur_op;
  logic [7:0] fr_op [32];
  int   fr_len [32];
  real  fr_t [32];
  logic [7:0] pb [64];
  real  t_rise, min_gap;

  function automatic logic [31:0] status_now();
    if (!clr_seen) return 32'h0;
    if (prog_seen) return final_st;
    if (polls >= poll_ok_at) return 32'h0001_0000;
    return 32'h0001_0001;
  endfunction

  function automatic logic [7:0] resp(int b);
    if (b < 4 || b > 7) return 8'h00;
    if (cur_op == 8'h07) return id_val[8*(7-b) +: 8];
    if (cur_op == 8'h09) return cur_st[8*(7-b) +: 8];
    return 8'h00;
  endfunction

  always @(negedge spi_cs_n) if (logging) begin
    bitc = 0; bytec = 0; rxs = 0; tx_sh = 0; spi_miso = 1'b0; cur_op = 8'hxx;
    if (nfr > 0 && ($realtime - t_rise) < min_gap) min_gap = $realtime - t_rise;
    if (nfr < 32) fr_t[nfr] = $realtime;
  end

  always @(posedge spi_sclk) if (logging && !spi_cs_n) begin
    rxs = {rxs[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      if (bytec == 0) begin
        cur_op = rxs;
        if (rxs == 8'h09) cur_st = status_now();
      end
      if (cur_op == 8'h41 && bytec < 64) pb[bytec] = rxs;
      if (bytec > 0 && cur_op != 8'h41 && rxs != 8'h00) pad_bad = 1;
      bytec++;
    end
  end

  always @(negedge spi_sclk) if (logging && !spi_cs_n) begin
    if (bitc == 0) tx_sh = resp(bytec);
    else tx_sh = {tx_sh[6:0], 1'b0};
    spi_miso = tx_sh[7];
  end

  always @(posedge spi_cs_n) if (logging) begin
    t_rise = $realtime;
    if (nfr < 32) begin fr_op[nfr] = cur_op; fr_len[nfr] = bytec; end
    nfr++;
    if (cur_op == 8'h09 && clr_seen && !prog_seen) polls++;
    if (cur_op == 8'h70) clr_seen = 1;
    if (cur_op == 8'h41) begin prog_seen = 1; prog_len = bytec; end
  end

  // ---- bitstream source ----
  int sidx = 0, scnt = 0;
  bit pend = 0, stall_en = 0;
  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  always @(negedge clk) begin
    if (pend) sidx++;
    bs_data  = pat(sidx);
    bs_valid = stall_en ? (scnt % 8 >= 3) : 1'b1;
    scnt++;
    pend = bs_valid && bs_ready;
  end

  task automatic clear_log();
    nfr = 0; polls = 0; clr_seen = 0; prog_seen = 0; pad_bad = 0; prog_len = 0;
    min_gap = 1.0e9; t_rise = 0.0;
  endtask

  task automatic run(int len, logic [31:0] idv, int okat, logic [31:0] fin, bit stall);
    @(posedge clk); #1;
    clear_log();
    id_val = idv; poll_ok_at = okat; final_st = fin; stall_en = stall;
    sidx = 0; pend = 0;
    bs_len = LEN_W'(len);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (len != 0) chk("R11", "busy after start", 32'(busy), 32'd1);
    for (int i = 0; i < 40000 && busy; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset();
    chk("R11", "reset cs_n", 32'(spi_cs_n), 32'd1);
    chk("R10", "reset sclk", 32'(spi_sclk), 32'd0);
    chk("R11", "reset busy", 32'(busy), 32'd0);
    chk("R11", "reset success", 32'(success), 32'd0);
    chk("R11", "reset err", 32'(err_code), 32'd0);
  endtask

  task automatic t_zero_len();
    run(0, 32'hC208_8080, 0, 32'h4000, 0);
    chk("R1", "zero len err", 32'(err_code), 32'd1);
    chk("R1", "zero len success", 32'(success), 32'd0);
    chk("R1", "zero len frames", 32'(nfr), 32'd0);
  endtask

  task automatic t_bad_id();
    run(4, 32'h1234_5678, 0, 32'h4000, 0);
    chk("R3", "bad id err", 32'(err_code), 32'd2);
    chk("R3", "bad id frames", 32'(nfr), 32'd1);
    chk("R2", "id opcode", 32'(fr_op[0]), 32'h07);
    chk("R2", "id length", 32'(fr_len[0]), 32'd8);
    chk("R2", "id padding", 32'(pad_bad), 32'd0);
    chk("R3", "bad id busy", 32'(busy), 32'd0);
  endtask

  task automatic check_prog(string req, int n);
    chk(req, "prog length", 32'(prog_len), 32'(n + 8));
    for (int i = 0; i < n + 8; i++) begin
      logic [7:0] e;
      if (i == 0) e = 8'h41;
      else if (i < 4) e = 8'hFF;
      else if (i < n + 4) e = pat(i - 4);
      else e = 8'h00;
      chk(req, $sformatf("prog byte %0d", i), 32'(pb[i]), 32'(e));
    end
  endtask

  task automatic t_good();
    logic [7:0] eo [11] = '{8'h07, 8'h09, 8'h71, 8'h4A, 8'h70, 8'h09, 8'h09, 8'h09, 8'h41, 8'h4F, 8'h09};
    int el [11] = '{8, 8, 4, 4, 4, 8, 8, 8, 13, 4, 8};
    run(5, 32'hC208_8080, 2, 32'h0001_4000, 0);
    chk("R9", "good success", 32'(success), 32'd1);
    chk("R9", "good err", 32'(err_code), 32'd0);
    chk("R4", "good frame count", 32'(nfr), 32'd11);
    for (int i = 0; i < 11; i++) begin
      chk("R4", $sformatf("frame %0d opcode", i), 32'(fr_op[i]), 32'(eo[i]));
      chk("R4", $sformatf("frame %0d length", i), 32'(fr_len[i]), 32'(el[i]));
    end
    chk("R5", "poll count exact match", 32'(polls), 32'd3);
    chk("R5", "poll spacing 1", 32'((fr_t[6] - fr_t[5]) >= TICK * TCK), 32'd1);
    chk("R5", "poll spacing 2", 32'((fr_t[7] - fr_t[6]) >= TICK * TCK), 32'd1);
    chk("R10", "cs gap", 32'(min_gap >= 2 * CLK_DIV * TCK), 32'd1);
    chk("R4", "command padding", 32'(pad_bad), 32'd0);
    check_prog("R7", 5);
  endtask

  task automatic t_stall();
    run(9, 32'hC204_8080, 0, 32'h0000_4000, 1);
    chk("R3", "second id accepted", 32'(success), 32'd1);
    chk("R8", "stall frame count", 32'(nfr), 32'd9);
    chk("R8", "stall single poll", 32'(polls), 32'd1);
    check_prog("R8", 9);
  endtask

  task automatic t_not_done();
    run(3, 32'hC208_8080, 0, 32'h0001_0000, 0);
    chk("R9", "not done err", 32'(err_code), 32'd4);
    chk("R9", "not done success", 32'(success), 32'd0);
    chk("R9", "wrdis opcode", 32'(fr_op[7]), 32'h4F);
    chk("R9", "wrdis length", 32'(fr_len[7]), 32'd4);
  endtask

  task automatic t_timeout();
    run(3, 32'hC208_8080, 99, 32'h0000_4000, 0);
    chk("R6", "timeout err", 32'(err_code), 32'd3);
    chk("R6", "timeout polls", 32'(polls), 32'(MAXP));
    chk("R6", "no prog frame", 32'(prog_seen), 32'd0);
    repeat (20) @(posedge clk);
    #1;
    chk("R11", "result held", 32'(err_code), 32'd3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    logging = 1;
    @(posedge clk); #1;
    t_zero_len();
    t_bad_id();
    t_good();
    t_stall();
    t_not_done();
    t_timeout();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(TCK * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule